// File: doc/BRIEF.md
# Lazy Overflow Flag Evaluator

This block keeps the last flag-affecting arithmetic operation in deferred form instead of a finished overflow bit. A record port takes an operation kind, the source and destination operands as they stood before the operation, the result, and a byte/word width select. All of these are captured together on one clock edge.

The overflow flag is rebuilt from the stored record only when it is needed. The query output is combinational logic over the stored record, and each operation kind has its own formula. This lets an execution pipeline skip flag work for operations whose flags are never read, while the overflow bit stays available at any time.

Top module: `lazy_ovf_eval`

## Requirements
- R1: A synchronous active-high reset clears the record to kind EAGER with all stored values zero, so `ovf_out` reads 0 from the cycle after reset.
- R2: Kind INC (code 2): `ovf_out` is 1 exactly when the width-limited result equals 0x80 in byte mode or 0x8000 in word mode.
- R3: Kind DEC (code 1): `ovf_out` is 1 exactly when the width-limited result equals 0x7F in byte mode or 0x7FFF in word mode.
- R4: Kind SUB (code 4): `ovf_out` is 1 exactly when, at the sign position (bit 7 in byte mode, bit 15 in word mode), source and destination differ and destination and result differ.
- R5: Kind SHIFT (code 3): `ovf_out` is 1 exactly when the destination's sign bit (bit 7 or bit 15) differs from the result's sign bit.
- R6: Kind EAGER (code 0): `ovf_out` equals bit 11 of the stored 16-bit result. The width select has no effect on this kind.
- R7: Kind codes 5, 6 and 7 are unknown and give `ovf_out` = 0 whatever the operands are.
- R8: With `rec_byte` = 1, bits 15:8 of source, destination and result have no effect on `ovf_out` for kinds 1 to 4.
- R9: A record presented with `rec_valid` = 1 is captured on that clock edge. In the strobe cycle `ovf_out` still reflects the old record, and the new record is visible from the next cycle. While `rec_valid` = 0, the record input fields are ignored and the stored record is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record strobe |
| rec_kind | input | 3 | Operation kind code |
| rec_src | input | 16 | Source operand before the operation |
| rec_dst | input | 16 | Destination operand before the operation |
| rec_res | input | 16 | Operation result |
| rec_byte | input | 1 | 1 = byte width, 0 = word width |
| ovf_out | output | 1 | Overflow flag derived from the stored record |

## Verification
The bench goes after each exact boundary value:
- INC results of 0x80/0x8000 and DEC results of 0x7F/0x7FFF. A design with an off-by-one sign mask would miss these values or flag their neighbours.
- Byte-mode records that carry junk in the upper byte. These expose a design that compares or samples at bit 15 when it should use bit 7.
- EAGER records with byte select set. A design that masks here would lose bit 11.
- Unknown kind codes, which a design with an incomplete decode would turn into a spurious overflow.
- Strobe timing. The bench changes the record fields while the strobe is low, and checks the strobe cycle itself, so a design that captures on the wrong cycle, or never holds, shows up at once.

// File: rtl/lazy_ovf_pkg.sv
package lazy_ovf_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    OPK_EAGER = 3'd0,
    OPK_DEC   = 3'd1,
    OPK_INC   = 3'd2,
    OPK_SHIFT = 3'd3,
    OPK_SUB   = 3'd4
  } op_kind_e;
endpackage

// File: rtl/lazy_ovf_store.sv
module lazy_ovf_store
  import lazy_ovf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [KIND_W-1:0] wr_kind,
  input  logic [DATA_W-1:0] wr_src,
  input  logic [DATA_W-1:0] wr_dst,
  input  logic [DATA_W-1:0] wr_res,
  input  logic              wr_byte,
  output logic [KIND_W-1:0] q_kind,
  output logic [DATA_W-1:0] q_src,
  output logic [DATA_W-1:0] q_dst,
  output logic [DATA_W-1:0] q_res,
  output logic              q_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_kind <= OPK_EAGER;
      q_src  <= '0;
      q_dst  <= '0;
      q_res  <= '0;
      q_byte <= 1'b0;
    end else if (wr_en) begin
      q_kind <= wr_kind;
      q_src  <= wr_src;
      q_dst  <= wr_dst;
      q_res  <= wr_res;
      q_byte <= wr_byte;
    end
  end

  // R9: a strobe loads every field on the edge
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q_res == $past(wr_res)) && (q_dst == $past(wr_dst))
              && (q_src == $past(wr_src)) && (q_kind == $past(wr_kind)));

  // R9: without a strobe the record is held
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q_res) && $stable(q_dst) && $stable(q_src)
               && $stable(q_kind) && $stable(q_byte));
endmodule

// File: rtl/lazy_ovf_calc.sv
module lazy_ovf_calc
  import lazy_ovf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EAGER_BIT = 11
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] res,
  input  logic              is_byte,
  output logic              ovf
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LIM_BYTE  = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] SIGN_BYTE = DATA_W'(1) << (HALF_W - 1);
  localparam logic [DATA_W-1:0] SIGN_WORD = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] lim, sign_m, s_w, d_w, r_w;

  always_comb begin
    lim    = is_byte ? LIM_BYTE : '1;
    sign_m = is_byte ? SIGN_BYTE : SIGN_WORD;
    s_w    = src & lim;
    d_w    = dst & lim;
    r_w    = res & lim;
  end

  always_comb begin
    case (kind)
      OPK_EAGER: ovf = res[EAGER_BIT];
      OPK_DEC:   ovf = (r_w == (sign_m - DATA_W'(1)));
      OPK_INC:   ovf = (r_w == sign_m);
      OPK_SHIFT: ovf = |(sign_m & (d_w ^ r_w));
      OPK_SUB:   ovf = |(sign_m & (s_w ^ d_w) & (d_w ^ r_w));
      default:   ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/lazy_ovf_eval.sv
module lazy_ovf_eval
  import lazy_ovf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EAGER_BIT = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_valid,
  input  logic [KIND_W-1:0] rec_kind,
  input  logic [DATA_W-1:0] rec_src,
  input  logic [DATA_W-1:0] rec_dst,
  input  logic [DATA_W-1:0] rec_res,
  input  logic              rec_byte,
  output logic              ovf_out
);
  localparam int HALF_W = DATA_W / 2;

  logic [KIND_W-1:0] st_kind;
  logic [DATA_W-1:0] st_src, st_dst, st_res;
  logic              st_byte;

  lazy_ovf_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(rec_valid),
    .wr_kind(rec_kind), .wr_src(rec_src), .wr_dst(rec_dst),
    .wr_res(rec_res), .wr_byte(rec_byte),
    .q_kind(st_kind), .q_src(st_src), .q_dst(st_dst),
    .q_res(st_res), .q_byte(st_byte)
  );

  lazy_ovf_calc #(.DATA_W(DATA_W), .EAGER_BIT(EAGER_BIT)) u_calc (
    .kind(st_kind), .src(st_src), .dst(st_dst), .res(st_res),
    .is_byte(st_byte), .ovf(ovf_out)
  );

  // R1: reset leaves no overflow visible
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !ovf_out);

  // R7: unknown kinds never report overflow
  a_r7_unknown_kind: assert property (@(posedge clk) disable iff (rst)
    (st_kind > KIND_W'(4)) |-> !ovf_out);

  // R5: unchanged sign through a shift gives no overflow
  a_r5_shift_same: assert property (@(posedge clk) disable iff (rst)
    (st_kind == OPK_SHIFT && st_dst == st_res) |-> !ovf_out);

  // R4: subtract overflow needs operands of opposite sign
  a_r4_sub_signs: assert property (@(posedge clk) disable iff (rst)
    (st_kind == OPK_SUB && !st_byte && ovf_out) |-> (st_src[DATA_W-1] != st_dst[DATA_W-1]));

  // R6: eager kind follows the stored flag bit
  a_r6_eager_bit: assert property (@(posedge clk) disable iff (rst)
    (st_kind == OPK_EAGER) |-> (ovf_out == st_res[EAGER_BIT]));

  // R8: in byte mode an INC overflow means the low byte is exactly 0x80
  a_r8_byte_inc: assert property (@(posedge clk) disable iff (rst)
    (st_kind == OPK_INC && st_byte && ovf_out) |-> (st_res[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}}));
endmodule

// File: tb/lazy_ovf_eval_tb.sv
`timescale 1ns/1ps
module lazy_ovf_eval_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rec_valid = 1'b0;
  logic [2:0]  rec_kind = '0;
  logic [15:0] rec_src = '0, rec_dst = '0, rec_res = '0;
  logic        rec_byte = 1'b0;
  logic        ovf_out;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;

  // reference record
  int m_kind, m_src, m_dst, m_res;
  bit m_byte;
  bit m_after_reset;

  always #4 clk = ~clk;

  lazy_ovf_eval u_dut (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .rec_src(rec_src), .rec_dst(rec_dst), .rec_res(rec_res),
    .rec_byte(rec_byte), .ovf_out(ovf_out)
  );

  function automatic bit expect_ovf(int k, int s, int d, int r, bit b);
    int lim, msk;
    lim = b ? 'hFF : 'hFFFF;
    msk = b ? 'h80 : 'h8000;
    s = s & lim; d = d & lim;
    case (k)
      0: return ((r >> 11) & 1) != 0;
      1: return (r & lim) == msk - 1;
      2: return (r & lim) == msk;
      3: return ((d ^ (r & lim)) & msk) != 0;
      4: return ((s ^ d) & (d ^ (r & lim)) & msk) != 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int k, bit b, int s, int d, int r, bit fresh);
    if (fresh) return "R1";
    if (k > 4) return "R7";
    if (b && k != 0 && (((s | d | r) & 'hFF00) != 0)) return "R8";
    case (k)
      0: return "R6";
      1: return "R3";
      2: return "R2";
      3: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: ovf_out actual=%0b expected=%0b (kind=%0d byte=%0b)",
               req, act, exp, m_kind, m_byte);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_kind = 0; m_src = 0; m_dst = 0; m_res = 0; m_byte = 0; m_after_reset = 1;
    end else if (rec_valid) begin
      m_kind = rec_kind; m_src = rec_src; m_dst = rec_dst; m_res = rec_res;
      m_byte = rec_byte; m_after_reset = 0;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (started && !finished)
      check(ovf_out, expect_ovf(m_kind, m_src, m_dst, m_res, m_byte),
            tag_of(m_kind, m_byte, m_src, m_dst, m_res, m_after_reset));
  end

  task automatic put(int k, int s, int d, int r, bit b);
    @(negedge clk);
    rec_valid = 1'b1; rec_kind = 3'(k); rec_src = 16'(s);
    rec_dst = 16'(d); rec_res = 16'(r); rec_byte = b;
    #1;
    // R9: strobe cycle still shows the previous record
    check(ovf_out, expect_ovf(m_kind, m_src, m_dst, m_res, m_byte), "R9");
    @(posedge clk);
    #1 rec_valid = 1'b0;
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rec_valid = 1'b0;
      rec_kind = 3'($urandom); rec_src = 16'($urandom);
      rec_dst = 16'($urandom); rec_res = 16'($urandom); rec_byte = 1'($urandom);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    started = 1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ovf_out, 1'b0, "R1");

    // R2 increment boundaries
    put(2, 0, 'h7F, 'h80, 1);     idle_junk(2);
    put(2, 0, 'h7FFF, 'h8000, 0); idle_junk(1);
    put(2, 0, 'h7F, 'h80, 0);
    put(2, 0, 'h7E, 'h7F, 1);
    // R3 decrement boundaries
    put(1, 0, 'h80, 'h7F, 1);
    put(1, 0, 'h8000, 'h7FFF, 0);
    put(1, 0, 'h80, 'h7F, 0);
    put(1, 0, 'h81, 'h80, 1);
    // R4 subtract
    put(4, 'h01, 'h80, 'h7F, 1);
    put(4, 'h8001, 'h7FFF, 'h8000, 0);
    put(4, 'h01, 'h05, 'h04, 1);
    put(4, 'hFF, 'h80, 'h81, 1);
    // R5 shift
    put(3, 1, 'h40, 'h80, 1);
    put(3, 1, 'h4000, 'h8000, 0);
    put(3, 1, 'hC0, 'h80, 1);
    put(3, 1, 'h4000, 'h0000, 1);
    // R6 eager, width select ignored
    put(0, 0, 0, 'h0800, 0);
    put(0, 0, 0, 'h0800, 1);
    put(0, 0, 0, 'hF7FF, 1);
    // R7 unknown kinds
    put(5, 'hFFFF, 'h0000, 'h8000, 0);
    put(6, 'h8001, 'h7FFF, 'h8000, 0);
    put(7, 0, 'h7F, 'h80, 1);
    // R8 upper-byte junk in byte mode
    put(2, 'hAB00, 'hCD7F, 'hEE80, 1);
    put(1, 'h1200, 'h3480, 'hFF7F, 1);
    put(3, 'h9900, 'hFF40, 'h0080, 1);
    put(4, 'h8001, 'h0080, 'h807F, 1);
    put(2, 0, 0, 'h8080, 1);
    idle_junk(4);

    // mixed records
    for (int i = 0; i < 400; i++) begin
      put(int'($urandom_range(0, 7)), int'($urandom & 'hFFFF),
          int'($urandom & 'hFFFF), int'($urandom & 'hFFFF), 1'($urandom));
      if ((i % 7) == 0) idle_junk(int'($urandom_range(1, 3)));
    end

    // R1 reset mid-run
    put(2, 0, 0, 'h8000, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(ovf_out, 1'b0, "R1");
    idle_junk(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule